// File: doc/BRIEF.md
# Reset Pin Qualifier and Stretcher

This block decides when the chip core is held in reset. It watches a bidirectional, active-low reset pad that has an external pull-up, and it takes reset requests from inside the chip. A low level that another device or a capacitor puts on the pad is accepted as a reset only after it has been held long enough. Short glitches and brief pulses are rejected.

An internal request from the watchdog or from the power monitor has a second effect. The block pulls the pad low through an open-drain driver for a minimum stretch, so that the parts on the board reset along with the core. The watchdog source is accepted only after it has been armed, and once armed it stays armed. The block gives out a synchronous core reset. It also gives a one-cycle wake strobe, which takes the core out of idle or power-down when a reset begins during a low-power state.

Top module: `pin_reset_ctrl`

## Requirements
- R1: The pad level passes through a two-stage synchronizer. If the pad is low at 64 consecutive rising clock edges, `coreRst` is high after the third rising edge that follows the last of them. If the pad is low at only 63 consecutive edges, `coreRst` stays low.
- R2: Any high level seen by the synchronizer restarts the low-run count from zero. Two low runs of 40 edges, split by one high edge, do not assert `coreRst`.
- R3: A request sampled high at a rising edge makes `padPullLow` high from that edge on. After the last edge with a request, `padPullLow` stays high for exactly 12 cycles, counted from that edge, and then goes low. A single-cycle request therefore gives exactly 12 high cycles.
- R4: `coreRst` is high one edge after the pull-low stretch or a qualified external reset is active. It is released at the rising edge after both have ended.
- R5: While the block pulls the pad low, and for two cycles after it releases the pad, the low-run count is held at zero. As a result, an external low level held for 70 edges from the start of a 12-cycle stretch does not produce an external reset.
- R6: `wakePulse` is high for exactly one cycle, on the cycle in which `coreRst` goes from low to high while `lowPower` was high at that edge. `wakePulse` is never high while `lowPower` is low.
- R7: A watchdog request has no effect until `wdogArm` has been sampled high at an earlier edge. From then on, watchdog requests are honoured until the next power-on reset, even if `wdogArm` returns low.
- R8: A power-monitor request starts the stretch at any time, whatever the arming state.
- R9: While `arstN` is low, `coreRst` is 1, `padPullLow` is 0 and `wakePulse` is 0. With the pad high, `coreRst` falls at the first rising edge after `arstN` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arstN | input | 1 | Asynchronous power-on reset of this block, active low |
| padIn | input | 1 | Level read back from the reset pad |
| wdogArm | input | 1 | Arms the watchdog request path (sticky) |
| wdogReq | input | 1 | Watchdog timeout request |
| pmonReq | input | 1 | Power-monitor reset request |
| lowPower | input | 1 | Core is in idle or power-down |
| padPullLow | output | 1 | Open-drain enable that pulls the pad low |
| coreRst | output | 1 | Synchronous core reset, active high |
| wakePulse | output | 1 | One-cycle low-power exit strobe |

## Verification
The external filter is driven with low runs of exactly 63 and 64 edges, which separates an off-by-one error in the hold limit or in the synchronizer depth. It is also driven with two runs of 40 split by one high edge, which shows whether a high sample truly restarts the count. Internal requests are tried as single-cycle pulses and as held requests, and the pull-low length is counted against 12. An external low that overlaps a stretch shows whether the block's own drive, and the synchronizer tail behind it, leak into the count. Watchdog requests before and after arming, with `lowPower` both set and clear, tell the sticky arm and the wake strobe apart from plain reset assertion.

// File: rtl/pin_reset_pkg.sv
package pin_reset_pkg;
  // Strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic holdClr;   // restart the low-run count
    logic holdInc;   // one more qualifying low sample
    logic strLoad;   // (re)start the pull-low stretch
    logic strDec;    // advance the stretch countdown
  } rstStrobes_t;
endpackage

// File: rtl/pin_reset_counters.sv
module pin_reset_counters
  import pin_reset_pkg::*;
#(
  parameter int HOLD_CYCLES    = 64,
  parameter int STRETCH_CYCLES = 12
) (
  input  logic        clk,
  input  logic        arstN,
  input  rstStrobes_t strb,
  output logic        holdFull,
  output logic        strActive
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYCLES);
  localparam logic [SW-1:0] STR_MAX  = SW'(STRETCH_CYCLES);

  logic [HW-1:0] holdCnt;
  logic [SW-1:0] strCnt;

  // Saturating run length of qualifying low samples
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                              holdCnt <= '0;
    else if (strb.holdClr)                   holdCnt <= '0;
    else if (strb.holdInc && holdCnt != HOLD_MAX) holdCnt <= holdCnt + 1'b1;
  end

  // Pull-low stretch countdown, reloaded by every request
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                          strCnt <= '0;
    else if (strb.strLoad)               strCnt <= STR_MAX;
    else if (strb.strDec && strCnt != '0) strCnt <= strCnt - 1'b1;
  end

  assign holdFull  = (holdCnt == HOLD_MAX);
  assign strActive = (strCnt != '0);

  // R1: a full count persists while no clear arrives
  p_full_holds_r1: assert property (@(posedge clk) disable iff (!arstN)
    holdFull && !strb.holdClr |=> holdFull);
  // R2: a clear always drops qualification on the next cycle
  p_clear_drops_r2: assert property (@(posedge clk) disable iff (!arstN)
    strb.holdClr |=> !holdFull);
  // R3: a load always leaves the stretch active
  p_load_active_r3: assert property (@(posedge clk) disable iff (!arstN)
    strb.strLoad |=> strActive);
endmodule

// File: rtl/pin_reset_seq.sv
module pin_reset_seq
  import pin_reset_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 12
) (
  input  logic        clk,
  input  logic        arstN,
  input  logic        padIn,
  input  logic        wdogArm,
  input  logic        wdogReq,
  input  logic        pmonReq,
  input  logic        lowPower,
  input  logic        holdFull,
  input  logic        strActive,
  output rstStrobes_t strb,
  output logic        coreRst,
  output logic        wakePulse
);
  localparam int RW = $clog2(STRETCH_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] ownShadow;
  logic wdogArmed, seenLow, selfMask, intReq, rstNext;

  // Pad synchronizer, resets to the idle (high) level
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end
  assign seenLow = !syncQ[SYNC_STAGES-1];

  // Trail of our own drive, covering the synchronizer latency
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) ownShadow <= '0;
    else        ownShadow <= {ownShadow[SYNC_STAGES-2:0], strActive};
  end
  assign selfMask = strActive | (|ownShadow);

  // One-way arming of the watchdog source
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)       wdogArmed <= 1'b0;
    else if (wdogArm) wdogArmed <= 1'b1;
  end

  assign intReq = pmonReq | (wdogReq & wdogArmed);

  always_comb begin
    strb.holdClr = !seenLow | selfMask;
    strb.holdInc = seenLow & !selfMask;
    strb.strLoad = intReq;
    strb.strDec  = 1'b1;
  end

  assign rstNext = holdFull | strActive;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      coreRst   <= 1'b1;
      wakePulse <= 1'b0;
    end else begin
      coreRst   <= rstNext;
      wakePulse <= lowPower & rstNext & !coreRst;
    end
  end

  // Run length of the current stretch, kept for the minimum-length check
  logic [RW-1:0] runLen;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                   runLen <= '0;
    else if (!strActive)          runLen <= '0;
    else if (runLen != RW'(STRETCH_CYCLES)) runLen <= runLen + 1'b1;
  end

  // R3: every stretch lasts at least the minimum
  p_pull_min_r3: assert property (@(posedge clk) disable iff (!arstN)
    $fell(strActive) |-> runLen == RW'(STRETCH_CYCLES));
  // R4: the core is in reset while the pad is pulled
  p_core_covers_pull_r4: assert property (@(posedge clk) disable iff (!arstN)
    strActive |=> coreRst);
  // R5: own drive never qualifies an external reset
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!arstN)
    selfMask |=> !holdFull);
  // R6: wake strobe is a single cycle and only from low power
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!arstN)
    wakePulse |=> !wakePulse);
  p_wake_lp_r6: assert property (@(posedge clk) disable iff (!arstN)
    wakePulse |-> $past(lowPower));
  // R7: arming cannot be withdrawn
  p_armed_sticky_r7: assert property (@(posedge clk) disable iff (!arstN)
    wdogArmed |=> wdogArmed);
endmodule

// File: rtl/pin_reset_ctrl.sv
module pin_reset_ctrl
  import pin_reset_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLD_CYCLES    = 64,
  parameter int STRETCH_CYCLES = 12
) (
  input  logic clk,
  input  logic arstN,
  input  logic padIn,
  input  logic wdogArm,
  input  logic wdogReq,
  input  logic pmonReq,
  input  logic lowPower,
  output logic padPullLow,
  output logic coreRst,
  output logic wakePulse
);
  rstStrobes_t strb;
  logic holdFull, strActive;

  pin_reset_seq #(.SYNC_STAGES(SYNC_STAGES), .STRETCH_CYCLES(STRETCH_CYCLES)) uSeq (
    .clk(clk), .arstN(arstN), .padIn(padIn), .wdogArm(wdogArm),
    .wdogReq(wdogReq), .pmonReq(pmonReq), .lowPower(lowPower),
    .holdFull(holdFull), .strActive(strActive), .strb(strb),
    .coreRst(coreRst), .wakePulse(wakePulse));

  pin_reset_counters #(.HOLD_CYCLES(HOLD_CYCLES), .STRETCH_CYCLES(STRETCH_CYCLES)) uCnt (
    .clk(clk), .arstN(arstN), .strb(strb),
    .holdFull(holdFull), .strActive(strActive));

  assign padPullLow = strActive;
endmodule

// File: tb/pin_reset_ctrl_test.sv
module pin_reset_ctrl_test;
  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic extHold = 1'b0, wdogArm = 1'b0, wdogReq = 1'b0, pmonReq = 1'b0, lowPower = 1'b0;
  logic padPullLow, coreRst, wakePulse, padIn;
  int checks = 0, fails = 0, cycles = 0, wakes = 0, pulls = 0;
  string phaseTag = "R9";

  always #2.5 clk = ~clk;  // 200 MHz

  assign padIn = !(extHold || padPullLow);

  pin_reset_ctrl uut (
    .clk(clk), .arstN(arstN), .padIn(padIn), .wdogArm(wdogArm), .wdogReq(wdogReq),
    .pmonReq(pmonReq), .lowPower(lowPower), .padPullLow(padPullLow),
    .coreRst(coreRst), .wakePulse(wakePulse));

  // Behavioural reference: the pad history, run length and stretch timer kept as plain integers
  bit padQ[$];
  bit pullTail[$];
  int lowRun, pullLeft;
  bit mArmed, mRst, mWake;

  always @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      padQ = '{1'b1, 1'b1};
      pullTail = '{1'b0, 1'b0};
      lowRun = 0; pullLeft = 0; mArmed = 0; mRst = 1; mWake = 0;
    end else begin
      bit seenLow, masked, padNow, req, rstNxt;
      padNow = !(extHold || pullLeft > 0);
      seenLow = !padQ[0];
      masked = (pullLeft > 0) || pullTail[0] || pullTail[1];
      rstNxt = (lowRun == 64) || (pullLeft > 0);
      mWake = lowPower && rstNxt && !mRst;
      mRst = rstNxt;
      req = pmonReq || (wdogReq && mArmed);
      lowRun = (seenLow && !masked) ? ((lowRun < 64) ? lowRun + 1 : 64) : 0;
      void'(pullTail.pop_front()); pullTail.push_back(pullLeft > 0);
      pullLeft = req ? 12 : ((pullLeft > 0) ? pullLeft - 1 : 0);
      if (wdogArm) mArmed = 1;
      void'(padQ.pop_front()); padQ.push_back(padNow);
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (padPullLow === 1'b1) pulls++;
    if (wakePulse === 1'b1) wakes++;
    check(phaseTag, padPullLow, pullLeft > 0, "padPullLow");
    check(phaseTag, coreRst, mRst, "coreRst");
    check(phaseTag, wakePulse, mWake, "wakePulse");
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      finishRun();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    idle(2);
    check("R9", coreRst, 1'b1, "coreRst in reset");
    check("R9", padPullLow, 1'b0, "padPullLow in reset");
    check("R9", wakePulse, 1'b0, "wakePulse in reset");
    arstN = 1'b1;
    idle(1);
    check("R9", coreRst, 1'b0, "coreRst after first edge");
    idle(5);

    // R1: 63 low edges are not enough
    phaseTag = "R1";
    extHold = 1; idle(63); extHold = 0;
    idle(6);
    check("R1", coreRst, 1'b0, "63-edge low run");
    // R1: 64 low edges qualify, three edges after the last
    extHold = 1; idle(64); extHold = 0;
    idle(2);
    check("R1", coreRst, 1'b0, "before qualification");
    idle(1);
    check("R1", coreRst, 1'b1, "64-edge low run");
    idle(8);
    check("R4", coreRst, 1'b0, "released after pad high");

    // R2: high sample restarts the count
    phaseTag = "R2";
    extHold = 1; idle(40); extHold = 0; idle(1); extHold = 1; idle(40); extHold = 0;
    idle(6);
    check("R2", coreRst, 1'b0, "split low runs");

    // R3, R8: single-cycle power-monitor request
    phaseTag = "R3";
    pulls = 0;
    pmonReq = 1; idle(1); pmonReq = 0;
    idle(20);
    check("R3", pulls == 12, 1'b1, "single pulse stretch length is 12");
    check("R8", coreRst, 1'b0, "released after stretch");
    // R3: held request extends the stretch
    pulls = 0;
    pmonReq = 1; idle(5); pmonReq = 0;
    idle(20);
    check("R3", pulls == 16, 1'b1, "held request stretch length is 16");

    // R5: external low overlapping own drive does not qualify
    phaseTag = "R5";
    pmonReq = 1; extHold = 1; idle(1); pmonReq = 0;
    idle(69); extHold = 0;
    idle(6);
    check("R5", coreRst, 1'b0, "overlap does not qualify");

    // R7: watchdog before arming is ignored
    phaseTag = "R7";
    pulls = 0;
    wdogReq = 1; idle(3); wdogReq = 0;
    idle(4);
    check("R7", pulls == 0, 1'b1, "unarmed watchdog ignored");
    wdogArm = 1; idle(1); wdogArm = 0;
    idle(2);
    wdogReq = 1; idle(1); wdogReq = 0;
    check("R7", padPullLow, 1'b1, "armed watchdog pulls pad");
    idle(20);

    // R6: wake only from low power
    phaseTag = "R6";
    wakes = 0;
    wdogReq = 1; idle(1); wdogReq = 0;
    idle(20);
    check("R6", wakes == 0, 1'b1, "no wake outside low power");
    lowPower = 1;
    wakes = 0;
    wdogReq = 1; idle(1); wdogReq = 0;
    idle(20);
    check("R6", wakes == 1, 1'b1, "one wake from watchdog in low power");
    wakes = 0;
    extHold = 1; idle(64); extHold = 0;
    idle(10);
    lowPower = 0;
    check("R6", wakes == 1, 1'b1, "one wake from pad in low power");
    idle(4);
    finishRun();
  end
endmodule